// File: doc/BRIEF.md
# Configurable Logic Cell with Arithmetic Mode

This block is one programmable logic cell. It holds a 16-entry truth table, a one-bit full adder and a D flip-flop. Three configuration-driven selectors connect these parts. A serial configuration chain loads all the cell's settings one bit per clock while the load enable is high. Once it is loaded, the cell serves the fabric through four data inputs, a carry-in, the cell output and a carry-out.

The table is stored as two 8-entry halves. Both halves are addressed by the three low data inputs. In logic mode, the top data input picks one of the two half outputs, so the cell computes any function of four inputs. In arithmetic mode, the two half outputs feed the full adder as its operands, together with the carry-in. The sum becomes the cell result, and the adder's carry goes out of the cell. An output-select bit decides whether the cell output shows the result straight away or the copy the flip-flop captured at the last rising clock edge.

Top module: `lcell`

## Requirements
- R1: The reset input `rst_n` is active-low and synchronous. A rising clock edge that sees it low clears the whole configuration word and the flip-flop to zero. With a zero configuration, `dout` and `cout` are both 0.
- R2: At each rising edge with `cfg_en` high, the configuration word shifts up by one place and `cfg_din` enters bit 0. After 18 such edges, the first bit sent sits in bit 17. The word layout is: bit 17 is the output select (1 = registered), bit 16 is the mode (1 = arithmetic), and bits 15..0 are the table T.
- R3: In logic mode, the cell result is T[din], where din is read as an unsigned index 0..15. Half A is T[7:0] and half B is T[15:8], both addressed by din[2:0], and din[3] picks half B.
- R4: In logic mode, `cout` is 0 and `cin` has no effect on `dout`.
- R5: In arithmetic mode, a = T[din[2:0]] and b = T[8 + din[2:0]]. The cell result is a XOR b XOR cin, `cout` is the majority of a, b and cin, and din[3] has no effect.
- R6: With output select 0, `dout` follows changes of `din` and `cin` in the same cycle, with no clock edge in between.
- R7: With output select 1, `dout` equals the cell result that was present just before the last rising edge. It does not change between edges.
- R8: While `cfg_en` is low, `cfg_din` has no effect on the configuration.
- R9: `cout` is always combinational, whatever the output select is set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| din | input | 4 | Cell data inputs |
| cin | input | 1 | Carry into the adder |
| dout | output | 1 | Cell output, registered or direct |
| cout | output | 1 | Carry out of the adder (0 in logic mode) |

## Verification
The checker compares the ports with the loaded configuration word on every cycle. It checks the table lookup in logic mode, the sum and majority carry in arithmetic mode, the zero carry in logic mode, the one-place shift when loading, the hold when not loading, and the one-cycle lag of the registered output. Some behaviours only the bench scenarios can show, because they depend on the serial bit order seen at the pins or on timing within a clock period. These are: the exact placement of the mode and output-select bits, the result of over-shifting a loaded word, reset clearing a live configuration, and a registered output holding steady while its inputs move between edges.

// File: rtl/lcell_pkg.sv
// Package lcell_pkg
// Shared constants and the configuration word layout for the logic cell.
// Assumes the input count is at least 2, so that the table splits into two halves.
package lcell_pkg;
    localparam int N_IN     = 4;
    localparam int LUT_BITS = 2 ** N_IN;
    localparam int HALF     = LUT_BITS / 2;
    localparam int SEL_W    = N_IN - 1;
    localparam int CFG_W    = LUT_BITS + 2;

    // MSB first: output select, mode, then the truth table
    typedef struct packed {
        logic                reg_sel;
        logic                arith;
        logic [LUT_BITS-1:0] tbl;
    } cell_cfg_t;
endpackage

// File: rtl/lcell_cfg_chain.sv
// Module lcell_cfg_chain
// Serial configuration register. Each enabled clock edge shifts the word up one
// place and takes the new bit into bit 0. Assumes the sender pushes bits MSB first.
module lcell_cfg_chain
    import lcell_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      shift_en,
    input  logic      shift_in,
    output cell_cfg_t cfg
);
    logic [CFG_W-1:0] word_q;

    // Clear on reset, shift when enabled, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (shift_en) begin
            word_q <= {word_q[CFG_W-2:0], shift_in};
        end
    end

    assign cfg = cell_cfg_t'(word_q);
endmodule

// File: rtl/lcell_lut.sv
// Module lcell_lut
// Splits the truth table into two halves and reads one bit from each at the
// same index. Assumes the table width is twice the size of one half.
module lcell_lut
    import lcell_pkg::*;
(
    input  logic [LUT_BITS-1:0] tbl,
    input  logic [SEL_W-1:0]    idx,
    output logic                half_a,
    output logic                half_b
);
    logic [HALF-1:0] lo_half;
    logic [HALF-1:0] hi_half;

    // Split the table into its lower and upper halves, one bit per entry
    for (genvar g = 0; g < HALF; g++) begin : g_split
        assign lo_half[g] = tbl[g];
        assign hi_half[g] = tbl[HALF + g];
    end

    // Read the addressed entry from both halves
    always_comb begin
        half_a = lo_half[idx];
        half_b = hi_half[idx];
    end
endmodule

// File: rtl/lcell_full_adder.sv
// Module lcell_full_adder
// One-bit full adder. It is purely combinational and has no assumptions.
module lcell_full_adder (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    // Sum and majority carry
    always_comb begin
        s  = a ^ b ^ ci;
        co = (a & b) | (a & ci) | (b & ci);
    end
endmodule

// File: rtl/lcell_out_stage.sv
// Module lcell_out_stage
// Output flip-flop and the selector between the registered and the direct
// result. Assumes that the select bit changes only through configuration.
module lcell_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic res,
    input  logic reg_sel,
    output logic out
);
    logic q;

    // Capture the cell result on every edge; reset clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= res;
        end
    end

    // Choose the registered or the direct path
    always_comb begin
        out = reg_sel ? q : res;
    end
endmodule

// File: rtl/lcell.sv
// Module lcell
// Configurable logic cell. In logic mode it computes any function of its four
// inputs; in arithmetic mode the two table halves feed a full adder. The output
// can be registered or direct. Assumes that configuration is loaded before use.
module lcell
    import lcell_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en,
    input  logic            cfg_din,
    input  logic [N_IN-1:0] din,
    input  logic            cin,
    output logic            dout,
    output logic            cout
);
    cell_cfg_t        cfg_s;
    logic [CFG_W-1:0] cfg_q;
    logic             half_a;
    logic             half_b;
    logic             sum;
    logic             carry;
    logic             res_comb;

    lcell_cfg_chain u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .shift_in (cfg_din),
        .cfg      (cfg_s)
    );

    assign cfg_q = cfg_s;

    lcell_lut u_lut (
        .tbl    (cfg_s.tbl),
        .idx    (din[SEL_W-1:0]),
        .half_a (half_a),
        .half_b (half_b)
    );

    lcell_full_adder u_fa (
        .a  (half_a),
        .b  (half_b),
        .ci (cin),
        .s  (sum),
        .co (carry)
    );

    // Mode selector: the adder sum, or the half chosen by the top input
    always_comb begin
        if (cfg_s.arith) begin
            res_comb = sum;
            cout     = carry;
        end else begin
            res_comb = din[N_IN-1] ? half_b : half_a;
            cout     = 1'b0;
        end
    end

    lcell_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .res     (res_comb),
        .reg_sel (cfg_s.reg_sel),
        .out     (dout)
    );
endmodule

// File: rtl/lcell_chk.sv
// Module lcell_chk
// Property checker for lcell. It is attached by the bind statement at the end of
// this file and sees the ports plus the loaded configuration word and the
// unregistered result.
module lcell_chk
    import lcell_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic             cfg_din,
    input logic [N_IN-1:0]  din,
    input logic             cin,
    input logic             dout,
    input logic             cout,
    input logic [CFG_W-1:0] cfg,
    input logic             res
);
    logic [N_IN-1:0] aidx;
    logic [N_IN-1:0] bidx;
    logic            ta;
    logic            tb;
    logic            mode;
    logic            rsel;

    // Independent model of the table reads
    always_comb begin
        aidx = {1'b0, din[SEL_W-1:0]};
        bidx = {1'b1, din[SEL_W-1:0]};
        ta   = cfg[aidx];
        tb   = cfg[bidx];
        mode = cfg[LUT_BITS];
        rsel = cfg[LUT_BITS+1];
    end

    a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (cfg[0] == $past(cfg_din)) && (cfg[CFG_W-1:1] == $past(cfg[CFG_W-2:0])));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg));

    a_r3_logic_out: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && !rsel) |-> dout == cfg[din]);

    a_r4_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> cout == 1'b0);

    a_r5_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !rsel) |-> dout == (ta ^ tb ^ cin));

    a_r9_carry: assert property (@(posedge clk) disable iff (!rst_n)
        mode |-> cout == ((ta & tb) | (ta & cin) | (tb & cin)));

    a_r7_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel && $past(rst_n)) |-> dout == $past(res));
endmodule

bind lcell lcell_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .din     (din),
    .cin     (cin),
    .dout    (dout),
    .cout    (cout),
    .cfg     (cfg_q),
    .res     (res_comb)
);

// File: tb/test_lcell.sv
module test_lcell;
    localparam int CLK_P = 10;
    localparam int NV    = 12;
    // Row layout: {cfg[17:0], din[3:0], cin, exp_dout, exp_cout}
    localparam logic [24:0] VECS [0:NV-1] = '{
        {18'h08000, 4'hF, 1'b0, 1'b1, 1'b0},  // R3 4-input AND, hit
        {18'h08000, 4'hE, 1'b0, 1'b0, 1'b0},  // R3 miss
        {18'h08000, 4'hF, 1'b1, 1'b1, 1'b0},  // R4 cin ignored
        {18'h0CCF0, 4'h6, 1'b0, 1'b1, 1'b0},  // R3 half A
        {18'h0CCF0, 4'h9, 1'b0, 1'b0, 1'b0},  // R3 half B
        {18'h0CCF0, 4'hA, 1'b1, 1'b1, 1'b0},  // R3 R4
        {18'h1CCF0, 4'h6, 1'b0, 1'b0, 1'b1},  // R5 1+1+0
        {18'h1CCF0, 4'h6, 1'b1, 1'b1, 1'b1},  // R5 1+1+1
        {18'h1CCF0, 4'h4, 1'b1, 1'b0, 1'b1},  // R5 1+0+1
        {18'h1CCF0, 4'h8, 1'b0, 1'b0, 1'b0},  // R5 0+0+0
        {18'h1CCF0, 4'h2, 1'b0, 1'b1, 1'b0},  // R5 0+1+0
        {18'h1CCF0, 4'hE, 1'b0, 1'b0, 1'b1}   // R5 din[3] ignored
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic [3:0] din = '0;
    logic       cin = 1'b0;
    logic       dout;
    logic       cout;
    int         errors = 0;
    int         checks = 0;

    lcell i_lcell (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .din(din), .cin(cin), .dout(dout), .cout(cout)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic load(input logic [17:0] w);
        for (int i = 17; i >= 0; i--) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_din = w[i];
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    task automatic apply(input logic [3:0] d, input logic c);
        @(negedge clk);
        din = d;
        cin = c;
        #1;
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 dout", dout, 1'b0);
        check("R1 cout", cout, 1'b0);
        rst_n = 1'b1;

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            load(VECS[v][24:7]);
            apply(VECS[v][6:3], VECS[v][2]);
            check($sformatf("R3/R4/R5 vec%0d dout", v), dout, VECS[v][1]);
            check($sformatf("R3/R4/R5 vec%0d cout", v), cout, VECS[v][0]);
        end

        // R6: direct output follows inputs with no edge in between
        load(18'h08000);
        @(negedge clk);
        din = 4'hF;
        #1 check("R6 rise", dout, 1'b1);
        din = 4'h7;
        #1 check("R6 fall", dout, 1'b0);

        // R8: cfg_din toggled with cfg_en low leaves the table unchanged
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            cfg_din = i[0];
        end
        apply(4'hF, 1'b0);
        check("R8 table kept", dout, 1'b1);

        // R2: one extra shift moves the bits up one place (mode <- old T[15], T <- 0001)
        @(negedge clk);
        cfg_en  = 1'b1;
        cfg_din = 1'b1;
        @(negedge clk);
        cfg_en = 1'b0;
        apply(4'h0, 1'b0);
        check("R2 shifted sum", dout, 1'b1);
        check("R2 shifted cout", cout, 1'b0);

        // R7: registered output lags by one edge; R9: carry stays direct
        load(18'h38000);
        apply(4'h0, 1'b0);
        @(negedge clk);
        #1 check("R7 low", dout, 1'b0);
        din = 4'hF;
        #1 check("R7 held between edges", dout, 1'b0);
        @(negedge clk);
        #1 check("R7 captured", dout, 1'b1);
        // T = 8000 in arithmetic mode: din=7 -> a=0, b=1, so the carry equals cin
        din = 4'h7;
        cin = 1'b1;
        #1 check("R9 carry direct", cout, 1'b1);

        // R1: reset clears a live configuration
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        din   = 4'hF;
        cin   = 1'b1;
        #1 check("R1 cleared dout", dout, 1'b0);
        check("R1 cleared cout", cout, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule